// File: doc/BRIEF.md
# CAN Receive Bit Conditioner

This block sits between the CAN transceiver pins and the protocol engine. It synchronises the raw receive line into the system clock domain. It picks the line the receiver listens to: the external pin in normal operation, or the node's own transmit bit in self-test loop-back. It then produces one decided bit value per CAN bit at the sample-point strobe. The strobe and the time-quantum tick come from an external bit-timing unit.

Two detection modes are offered. The first uses the single sample taken at the sample point. The second takes a majority vote over that sample and the samples taken at the two time quanta just before it. In loop-back the transmit pin is held recessive. The protocol engine flags the acknowledge slot, and during that slot the block supplies a dominant acknowledge itself, so the node accepts its own frame. The mode bits are taken in only while the block is disabled.

Top module: `can_rx_cond`

## Requirements
- R1: After reset, `rx_bit` is 1 (recessive), `rx_valid` is 0 and `tx_pin` is 1.
- R2: In loop-back mode (`cfg_loopback`=1 when enabled), the receive path uses `tx_bit` and ignores `rx_pin`.
- R3: In loop-back mode while enabled, `tx_pin` is 1 whatever the value of `tx_bit`.
- R4: In loop-back mode, a line sample taken while `ack_slot` is 1 is 0 (dominant), whatever the value of `tx_bit`. Outside loop-back, `ack_slot` has no effect.
- R5: In single-sample mode (`cfg_triple`=0), `rx_bit` equals the line value at the tick that carries `sample_pt`.
- R6: In triple-sample mode (`cfg_triple`=1), `rx_bit` is the majority of the line values at the sample-point tick and at the two ticks before it.
- R7: `rx_valid` is high for exactly one clock, in the cycle after a `sample_pt` strobe taken while enabled. `rx_bit` changes only together with `rx_valid`.
- R8: Outside loop-back while enabled, `tx_pin` follows `tx_bit`. The receive path uses `rx_pin` after a two-flop synchroniser.
- R9: `cfg_loopback` and `cfg_triple` are captured only while `enable` is 0. Changing them while enabled has no effect.
- R10: While `enable` is 0, `tx_pin` is 1 and no `rx_valid` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; the mode bits are captured while it is low |
| cfg_loopback | input | 1 | Loop-back self-test mode request |
| cfg_triple | input | 1 | 1 selects the three-sample majority, 0 the single sample |
| tq_tick | input | 1 | Time-quantum enable, one clock wide |
| sample_pt | input | 1 | Sample-point strobe, coincident with a `tq_tick` |
| tx_bit | input | 1 | Bit the protocol engine transmits |
| ack_slot | input | 1 | High during the acknowledge slot |
| rx_pin | input | 1 | Raw receive line from the transceiver |
| tx_pin | output | 1 | Transmit line to the transceiver |
| rx_bit | output | 1 | Decided bit value |
| rx_valid | output | 1 | One-clock pulse marking a new `rx_bit` |

## Verification
The transmit pin is combinational, so the bench checks it inside a quantum, after the inputs have settled. A change on `rx_pin` reaches the line after two clock edges. The bench therefore holds each quantum's value for three clocks before it raises the tick. The decided bit and its valid pulse are registered one edge after the sample-point tick, and the bench samples them at the next falling edge. One cycle after the pulse, `rx_valid` must be low again. After each mode change, the bench runs two quanta with no sample-point strobe before it compares any majority result.

// File: rtl/can_rx_cond.sv
module can_rx_cond #(
  parameter int SYNC_STAGES = 2,
  parameter bit IDLE_LEVEL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic cfg_loopback,
  input  logic cfg_triple,
  input  logic tq_tick,
  input  logic sample_pt,
  input  logic tx_bit,
  input  logic ack_slot,
  input  logic rx_pin,
  output logic tx_pin,
  output logic rx_bit,
  output logic rx_valid
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lb_q, tri_q;
  logic [1:0]             hist_q;
  logic                   line, vote, decided;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_pin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lb_q  <= 1'b0;
      tri_q <= 1'b0;
    end else if (!enable) begin
      lb_q  <= cfg_loopback;
      tri_q <= cfg_triple;
    end

  assign line    = lb_q ? (ack_slot ? ~IDLE_LEVEL : tx_bit) : sync_q[SYNC_STAGES-1];
  assign vote    = (hist_q[1] & hist_q[0]) | (hist_q[1] & line) | (hist_q[0] & line);
  assign decided = tri_q ? vote : line;
  assign tx_pin  = (!enable || lb_q) ? IDLE_LEVEL : tx_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  hist_q <= {2{IDLE_LEVEL}};
    else if (enable && tq_tick)  hist_q <= {hist_q[0], line};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_bit   <= IDLE_LEVEL;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= enable && tq_tick && sample_pt;
      if (enable && tq_tick && sample_pt) rx_bit <= decided;
    end

  p_mode_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> ($stable(lb_q) && $stable(tri_q)));

  p_valid_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(enable && tq_tick && sample_pt));

  p_bit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_bit));

  p_lb_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(lb_q && ack_slot && !tri_q)) |-> (rx_bit == ~IDLE_LEVEL));

  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !$past(tri_q)) |-> (rx_bit == $past(line)));

  p_lb_tx_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(cfg_loopback, 1) && lb_q) |-> tx_pin == IDLE_LEVEL);

endmodule

// File: tb/can_rx_cond_bench.sv
module can_rx_cond_bench;
  logic clk = 0, rst_n = 0;
  logic enable = 0, cfg_loopback = 0, cfg_triple = 0;
  logic tq_tick = 0, sample_pt = 0, tx_bit = 1, ack_slot = 0, rx_pin = 1;
  logic tx_pin, rx_bit, rx_valid;

  int n_cmp = 0, n_bad = 0;
  bit m_lb = 0, m_tri = 0, m_en = 0;
  logic [1:0] h = 2'b11;
  bit done = 0;

  always #2 clk = ~clk;

  can_rx_cond u_can_rx_cond (.*);

  function automatic bit maj(bit a, bit b, bit c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic bit exp_line(bit lb, bit rx, bit tx, bit ack);
    return lb ? (ack ? 1'b0 : tx) : rx;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_mode(bit lb, bit tri3);
    @(negedge clk);
    enable = 0; cfg_loopback = lb; cfg_triple = tri3;
    repeat (2) @(negedge clk);
    enable = 1; m_lb = lb; m_tri = tri3; m_en = 1;
  endtask

  task automatic quantum(bit rx, bit tx, bit ack, bit sp, string req);
    bit ln, e;
    @(negedge clk);
    rx_pin = rx; tx_bit = tx; ack_slot = ack; tq_tick = 0; sample_pt = 0;
    @(negedge clk);
    chk("R7", rx_valid, 1'b0);
    @(negedge clk);
    if (!m_en) chk("R10", tx_pin, 1'b1);
    else if (m_lb) chk("R3", tx_pin, 1'b1);
    else chk("R8", tx_pin, tx);
    ln = exp_line(m_lb, rx, tx, ack);
    e = m_tri ? maj(h[1], h[0], ln) : ln;
    @(negedge clk);
    tq_tick = 1; sample_pt = sp;
    @(negedge clk);
    tq_tick = 0; sample_pt = 0;
    if (m_en) begin
      chk(req, rx_valid, sp);
      if (sp) chk(req, rx_bit, e);
      h = {h[0], ln};
    end else chk("R10", rx_valid, 1'b0);
  endtask

  task automatic run_random(int n, string req);
    quantum($urandom_range(1), $urandom_range(1), 0, 0, req);
    quantum($urandom_range(1), $urandom_range(1), 0, 0, req);
    for (int i = 0; i < n; i++)
      quantum($urandom_range(1), $urandom_range(1),
              m_lb ? ($urandom_range(7) == 0) : $urandom_range(1),
              $urandom_range(2) == 0, req);
  endtask

  initial begin
    void'($urandom(32'hC0DE));
    repeat (2) @(negedge clk);
    chk("R1", rx_bit, 1'b1);
    chk("R1", rx_valid, 1'b0);
    chk("R1", tx_pin, 1'b1);
    rst_n = 1;
    // R10 disabled: no pulse, recessive tx
    quantum(0, 0, 0, 1, "R10");
    // R5 / R8 normal single sample
    set_mode(0, 0);
    run_random(60, "R5");
    quantum(0, 1, 1, 1, "R4");
    // R6 normal triple directed: two ones then a zero -> 1
    set_mode(0, 1);
    quantum(1, 0, 0, 0, "R6"); quantum(1, 0, 0, 0, "R6"); quantum(0, 0, 0, 1, "R6");
    quantum(0, 0, 0, 0, "R6"); quantum(1, 0, 0, 0, "R6"); quantum(1, 0, 0, 1, "R6");
    run_random(60, "R6");
    // R2 loop-back single: rx_pin opposes tx_bit
    set_mode(1, 0);
    quantum(0, 1, 0, 1, "R2"); quantum(1, 0, 0, 1, "R2");
    quantum(1, 1, 1, 1, "R4");
    run_random(60, "R2");
    set_mode(1, 1);
    run_random(60, "R6");
    // R9: change cfg while enabled, behaviour stays loop-back triple
    @(negedge clk); cfg_loopback = 0; cfg_triple = 0;
    quantum(0, 1, 0, 0, "R9"); quantum(0, 1, 0, 0, "R9");
    quantum(1, 0, 0, 1, "R9");
    run_random(20, "R9");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule